// File: doc/BRIEF.md
# Sub-band Energy and Peak Reducer

The block reduces a stream of complex samples (signed 16-bit real and imaginary parts in Q1.15) into per-band statistics. A start pulse latches three settings: the number of bands L, the common band length M and the first vector position I. Band k then covers vector positions I+k·M through I+(k+1)·M−1, so the bands sit back to back. For each band the unit forms the squared modulus re²+im² of every sample and produces three results: the sum of those values (the band energy), their largest value (the peak) and the vector position of the first sample that reaches that peak.

Samples arrive with a valid strobe. Each accepted sample takes the next vector position, starting from zero after the start pulse. Samples that lie before I or after the last band, and samples offered while no run is active, are consumed and have no effect. One result beat leaves the block after each band closes. A done pulse follows the beat of the final band. A reduction over the whole vector is the configuration L=1, M=N, I=0.

Top module: `band_power_peak`

## Requirements
- R1: `res_energy` equals the sum of re²+im² over the band's samples, with re and im read as signed two's-complement 16-bit values.
- R2: `res_max` equals the largest re²+im² in the band. This is the squared modulus, as an unsigned 32-bit value.
- R3: `res_argmax` is the absolute vector position (0 is the first accepted sample after start) of the first sample in the band whose squared modulus equals `res_max`. Equal later values never replace it.
- R4: Band k (counted from 0 and reported on `res_band`) covers positions I+k·M to I+(k+1)·M−1. Its beat comes out after the beat of band k−1. Only cycles with `in_valid` high advance the position.
- R5: Each band yields exactly one `res_valid` beat, in the cycle after its last sample is accepted. Consecutive bands share no accumulated state, so bands of length 1 give beats in consecutive cycles.
- R6: Samples at positions below I or at or above I+L·M, and samples offered while no run is active (before any start, or after the final band), change no result and produce no beat.
- R7: `done` pulses high for one cycle, once per run, in the cycle after the final band's beat.
- R8: With L=1, M=N and I=0 the block reports one beat covering the whole N-sample vector.
- R9: During and directly after reset, `res_valid` and `done` are low and `res_energy` is zero.
- R10: The 44-bit energy never wraps. A band of 4096 samples of (−32768, −32768) reports 2^43 as the energy, 2^31 as the peak and position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Latches the settings and begins a run |
| cfg_count | input | 13 | Number of bands L (1 or more) |
| cfg_size | input | 13 | Samples per band M (1 to 4096) |
| cfg_base | input | 12 | Vector position I where band 0 starts |
| in_valid | input | 1 | Sample strobe |
| in_re | input | 16 | Real part, signed Q1.15 |
| in_im | input | 16 | Imaginary part, signed Q1.15 |
| res_valid | output | 1 | One-cycle result beat |
| res_energy | output | 44 | Band energy |
| res_max | output | 32 | Band peak squared modulus |
| res_argmax | output | 12 | Position of the first peak sample |
| res_band | output | 13 | Band number k |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The assertions assume a legal setup. L and M are at least 1, I+L·M does not exceed 4096, and `start` is never raised in the same cycle as a sample. Under those conditions band numbers step by one, a peak never exceeds its energy, and a finishing band is always followed by a beat. The stimulus issues `start` only with `in_valid` low and keeps every configured region inside 4096 positions. Samples outside the region carry extreme values, so a leak shows up in the results without breaking any assumption.

// File: rtl/bpp_pkg.sv
`timescale 1ns/1ps
package bpp_pkg;
  // per-sample events produced by the band sequencer
  typedef struct packed {
    logic take;   // sample lies in the active region
    logic first;  // first sample of a band
    logic last;   // last sample of a band
    logic fin;    // last sample of the final band
  } band_evt_t;
endpackage

// File: rtl/band_seq.sv
`timescale 1ns/1ps
module band_seq
  import bpp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W:0]   cfg_count,
  input  logic [IDX_W:0]   cfg_size,
  input  logic [IDX_W-1:0] cfg_base,
  input  logic             in_valid,
  output band_evt_t        evt,
  output logic [IDX_W-1:0] pos_idx,
  output logic [IDX_W:0]   band_no,
  output logic             done
);
  localparam int CNT_W = IDX_W + 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, size_q, idx_q, pos_q, band_q;
  logic [IDX_W-1:0] base_q;
  logic             fin_q, done_q;

  // named event wires
  logic in_region;
  assign in_region = busy_q && in_valid && (idx_q >= {1'b0, base_q});

  always_comb begin
    evt.take  = in_region;
    evt.first = in_region && (pos_q == '0);
    evt.last  = in_region && (pos_q == size_q - CNT_W'(1));
    evt.fin   = evt.last && (band_q == cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      size_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
      pos_q  <= '0;
      band_q <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      busy_q <= (cfg_count != '0) && (cfg_size != '0);
      cnt_q  <= cfg_count;
      size_q <= cfg_size;
      base_q <= cfg_base;
      idx_q  <= '0;
      pos_q  <= '0;
      band_q <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fin_q  <= evt.fin;
      done_q <= fin_q;
      if (busy_q && in_valid) idx_q <= idx_q + CNT_W'(1);
      if (evt.take) begin
        if (evt.last) begin
          pos_q <= '0;
          if (evt.fin) busy_q <= 1'b0;
          else         band_q <= band_q + CNT_W'(1);
        end else begin
          pos_q <= pos_q + CNT_W'(1);
        end
      end
    end
  end

  assign pos_idx = idx_q[IDX_W-1:0];
  assign band_no = band_q;
  assign done    = done_q;

  // R4: closing a non-final band moves to the next band number
  p_band_step_r4: assert property (@(posedge clk) disable iff (rst)
    (evt.last && !evt.fin && !start) |=> band_q == $past(band_q) + CNT_W'(1));

  // R6: an accepted sample always lies inside the configured region
  p_inside_region_r6: assert property (@(posedge clk) disable iff (rst)
    evt.take |-> (idx_q >= {1'b0, base_q}) && (band_q < cnt_q));

  // R7: done lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/band_acc.sv
`timescale 1ns/1ps
module band_acc #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic                     first,
  input  logic                     last,
  input  logic [IDX_W-1:0]         pos_idx,
  input  logic [IDX_W:0]           band_no,
  input  logic signed [DATA_W-1:0] s_re,
  input  logic signed [DATA_W-1:0] s_im,
  output logic                     res_valid,
  output logic [2*DATA_W+IDX_W-1:0] res_energy,
  output logic [2*DATA_W-1:0]      res_max,
  output logic [IDX_W-1:0]         res_argmax,
  output logic [IDX_W:0]           res_band
);
  localparam int MAG_W = 2 * DATA_W;
  localparam int ACC_W = MAG_W + IDX_W;

  // squared modulus; full-scale sum 2^31 still fits unsigned MAG_W
  function automatic logic [MAG_W-1:0] sq_mag(input logic signed [DATA_W-1:0] re,
                                              input logic signed [DATA_W-1:0] im);
    logic signed [MAG_W-1:0] rr, ii;
    rr = MAG_W'(re) * MAG_W'(re);
    ii = MAG_W'(im) * MAG_W'(im);
    return $unsigned(rr) + $unsigned(ii);
  endfunction

  // strict compare keeps the earliest position on ties
  function automatic logic beats(input logic [MAG_W-1:0] cand, input logic [MAG_W-1:0] cur);
    return cand > cur;
  endfunction

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [MAG_W-1:0] max_q, max_n, mag;
  logic [IDX_W-1:0] arg_q, arg_n;
  logic             new_peak;

  always_comb begin
    mag      = sq_mag(s_re, s_im);
    acc_n    = first ? ACC_W'(mag) : acc_q + ACC_W'(mag);
    new_peak = first || beats(mag, max_q);
    max_n    = new_peak ? mag : max_q;
    arg_n    = new_peak ? pos_idx : arg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      max_q      <= '0;
      arg_q      <= '0;
      res_valid  <= 1'b0;
      res_energy <= '0;
      res_max    <= '0;
      res_argmax <= '0;
      res_band   <= '0;
    end else begin
      res_valid <= take && last;
      if (take) begin
        if (last) begin
          res_energy <= acc_n;
          res_max    <= max_n;
          res_argmax <= arg_n;
          res_band   <= band_no;
          acc_q      <= '0;
          max_q      <= '0;
          arg_q      <= '0;
        end else begin
          acc_q <= acc_n;
          max_q <= max_n;
          arg_q <= arg_n;
        end
      end
    end
  end

  // R2: a band peak never exceeds the band energy
  p_max_le_energy_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ACC_W'(res_max) <= res_energy);

  // R1: zero energy implies a zero peak
  p_zero_energy_r1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_energy == '0) |-> res_max == '0);

  // R1: within a band the running energy never decreases
  p_energy_grows_r1: assert property (@(posedge clk) disable iff (rst)
    (take && !first && !last) |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/band_power_peak.sv
`timescale 1ns/1ps
module band_power_peak
  import bpp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [IDX_W:0]             cfg_count,
  input  logic [IDX_W:0]             cfg_size,
  input  logic [IDX_W-1:0]           cfg_base,
  input  logic                       in_valid,
  input  logic signed [DATA_W-1:0]   in_re,
  input  logic signed [DATA_W-1:0]   in_im,
  output logic                       res_valid,
  output logic [2*DATA_W+IDX_W-1:0]  res_energy,
  output logic [2*DATA_W-1:0]        res_max,
  output logic [IDX_W-1:0]           res_argmax,
  output logic [IDX_W:0]             res_band,
  output logic                       done
);
  band_evt_t        evt;
  logic [IDX_W-1:0] pos_idx;
  logic [IDX_W:0]   band_no;

  band_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_count(cfg_count), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .in_valid(in_valid), .evt(evt), .pos_idx(pos_idx), .band_no(band_no),
    .done(done)
  );

  band_acc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst),
    .take(evt.take), .first(evt.first), .last(evt.last),
    .pos_idx(pos_idx), .band_no(band_no), .s_re(in_re), .s_im(in_im),
    .res_valid(res_valid), .res_energy(res_energy), .res_max(res_max),
    .res_argmax(res_argmax), .res_band(res_band)
  );

  // R7: the final band's sample is followed by its result beat
  p_fin_gives_beat_r7: assert property (@(posedge clk) disable iff (rst)
    evt.fin |=> res_valid);

  // R7: done only ever follows a result beat
  p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(res_valid));
endmodule

// File: tb/tb_band_power_peak.sv
`timescale 1ns/1ps
module tb_band_power_peak;
  localparam int DW = 16;
  localparam int IW = 12;
  localparam int CW = IW + 1;
  localparam int MW = 2 * DW;
  localparam int AW = MW + IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic [CW-1:0] cfg_size = '0;
  logic [IW-1:0] cfg_base = '0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic res_valid, done;
  logic [AW-1:0] res_energy;
  logic [MW-1:0] res_max;
  logic [IW-1:0] res_argmax;
  logic [CW-1:0] res_band;

  always #2.5 clk = ~clk;

  band_power_peak #(.DATA_W(DW), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_count(cfg_count), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .res_valid(res_valid), .res_energy(res_energy), .res_max(res_max),
    .res_argmax(res_argmax), .res_band(res_band), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor
  longint got_e[16];
  longint got_m[16];
  int     got_a[16];
  int     got_b[16];
  int     n_res = 0;
  int     n_done = 0;
  int     res_cyc = 0;
  int     done_cyc = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (n_res < 16) begin
          got_e[n_res] = longint'(res_energy);
          got_m[n_res] = longint'(res_max);
          got_a[n_res] = int'(res_argmax);
          got_b[n_res] = int'(res_band);
        end
        n_res   = n_res + 1;
        res_cyc = cyc;
      end
      if (done) begin
        n_done   = n_done + 1;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // sample patterns, restated independently of the design
  function automatic void gen(input int mode, input int i, output int re, output int im);
    case (mode)
      1: begin re = -32768; im = -32768; end
      2: begin
        if (i % 3 == 1) begin
          if (i % 2 == 1) begin re = 0; im = 1000; end
          else begin re = -1000; im = 0; end
        end else begin
          re = i % 5; im = -(i % 7);
        end
      end
      default: begin
        re = (((i * 7919 + mode * 31) % 4001) - 2000) * 8;
        im = (((i * 104729 + mode * 17) % 3001) - 1500) * 8;
      end
    endcase
  endfunction

  task automatic run_case(input string tag, input string cnt_rq, input int mode,
                          input int L, input int M, input int I, input int tail, input bit gaps);
    int nfeed;
    int exp_cyc;
    nfeed   = I + L * M + tail;
    exp_cyc = -1;
    @(negedge clk);
    n_res = 0; n_done = 0;
    cfg_count = CW'(L); cfg_size = CW'(M); cfg_base = IW'(I);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nfeed; i++) begin
      int re, im;
      if (i >= I && i < I + L * M) gen(mode, i, re, im);
      else begin re = 32767; im = -32768; end
      in_valid = 1'b1; in_re = DW'(re); in_im = DW'(im);
      @(negedge clk);
      if (i == I + L * M - 1) exp_cyc = cyc;
      if (gaps && (i % 3 == 0)) begin
        in_valid = 1'b0; in_re = 16'sh7fff; in_im = 16'sh7fff;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(cnt_rq, {tag, " beat count"}, n_res, L);
    for (int k = 0; k < L && k < 16; k++) begin
      longint e, m;
      int a;
      e = 0; m = -1; a = 0;
      for (int j = 0; j < M; j++) begin
        int i2, re2, im2;
        longint s;
        i2 = I + k * M + j;
        gen(mode, i2, re2, im2);
        s = longint'(re2) * re2 + longint'(im2) * im2;
        e += s;
        if (s > m) begin m = s; a = i2; end
      end
      chk("R1", {tag, " energy"}, got_e[k], e);
      chk("R2", {tag, " peak"}, got_m[k], m);
      chk("R3", {tag, " peak position"}, got_a[k], a);
      chk("R4", {tag, " band number"}, got_b[k], k);
    end
    chk("R5", {tag, " final beat cycle"}, res_cyc, exp_cyc);
    chk("R7", {tag, " done count"}, n_done, 1);
    chk("R7", {tag, " done cycle"}, done_cyc, res_cyc + 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R9", "valid in reset", res_valid, 0);
    chk("R9", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "valid after reset", res_valid, 0);
    chk("R9", "done after reset", done, 0);
    chk("R9", "energy after reset", longint'(res_energy), 0);
  endtask

  task automatic t_idle(input string tag);
    @(negedge clk);
    n_res = 0; n_done = 0;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_re = 16'sh4000; in_im = -16'sh4000;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", {tag, " idle beats"}, n_res, 0);
    chk("R6", {tag, " idle done"}, n_done, 0);
  endtask

  task automatic t_whole();   run_case("whole vector", "R8", 0, 1, 64, 0, 0, 1'b0); endtask
  task automatic t_bands();   run_case("offset bands", "R6", 3, 4, 8, 5, 6, 1'b0); endtask
  task automatic t_ties();    run_case("tied peaks",   "R3", 2, 2, 6, 0, 0, 1'b0); endtask
  task automatic t_gaps();    run_case("strobe gaps",  "R4", 0, 3, 5, 2, 3, 1'b1); endtask
  task automatic t_unit();    run_case("unit bands",   "R5", 4, 3, 1, 1, 2, 1'b0); endtask
  task automatic t_full();    run_case("full scale",   "R10", 1, 1, 4096, 0, 0, 1'b0); endtask

  task automatic t_full_values();
    chk("R10", "full scale energy", got_e[0], longint'(1) << 43);
    chk("R10", "full scale peak", got_m[0], longint'(1) << 31);
    chk("R10", "full scale position", got_a[0], 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_idle("before start");
    t_whole();
    t_bands();
    t_idle("after run");
    t_ties();
    t_gaps();
    t_unit();
    t_full();
    t_full_values();
    summary();
    $finish;
  end
endmodule